// File: doc/BRIEF.md
# Exclusive Access Monitor

This block sits on the memory side of a shared bus and lets several processors build locks and lock-free updates from paired exclusive-load and exclusive-store requests. Nobody has to hold the bus to do this. An exclusive load returns the aligned 64-bit word. It also arms a reservation for the requesting processor on the 8-byte block that holds the address. A later exclusive store from the same processor writes only if that reservation is still intact, and it reports the outcome as pass or fail.

Each processor has its own request port. A port carries a type, an address, a size of 1, 2, 4 or 8 bytes, and lane-positioned write data. Every port is serviced in every cycle. The block holds a small word memory so that reads and writes resolve in a defined order. A separate snoop input reports writes made by agents outside the ports, and those writes also break reservations. Atomicity depends on the address of a write and never on the data value. A location that is rewritten with the value it already holds therefore still makes a pending exclusive store fail.

Top module: `excl_monitor`

## Requirements
- R1: A request with type code 0 (load) or 2 (exclusive load) raises rvalid_o of its port in the next cycle. In that cycle rdata_o holds the aligned 64-bit word at address bits [ADDR_W-1:3]. The word is read as it was before any write in the request's own cycle.
- R2: A store (type 1) writes only the bytes given by the size code: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes and 3 is 8 bytes. The bytes start at lane addr[2:0] rounded down to a multiple of the size. Byte lane k is taken from wdata bits [8k+7:8k].
- R3: An exclusive store (type 3) passes only when its port holds a reservation on the same 8-byte block. That reservation must have been armed by the port's latest exclusive load, and no write from another port or from the snoop input may have reached the block since. A passing exclusive store writes the bytes it selects, in the same way as R2.
- R4: One cycle after an exclusive store, xs_valid_o of its port is 1 and xs_fail_o shows the outcome: 0 means the store passed and 1 means it failed. xs_valid_o is 0 in the cycle after any other request or an idle cycle.
- R5: A failing exclusive store writes no byte.
- R6: A write from another port clears the reservation even when it stores the value the location already holds.
- R7: A new exclusive load from a port replaces that port's earlier reservation. A port holds at most one reservation.
- R8: An exclusive store clears its port's reservation whether it passes or fails.
- R9: A write from another port to any byte of a reserved block clears the reservation, and so does a snoop hit on that block. A normal store from the owning port does not clear it.
- R10: Within one cycle, requests take effect in a fixed order: the snoop first, then the ports in ascending index. An exclusive store fails if the snoop or a lower-index port writes its block in the same cycle. An exclusive load arms no reservation if the snoop or any other port writes its block in that cycle.
- R11: The block never stalls. All ports may issue requests in the same cycle, and each one is answered in the next cycle.
- R12: After reset, no reservation is held, rvalid_o and xs_valid_o are 0, and every memory word reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | NUM_PORTS | Request present, one bit per port |
| req_type_i | input | NUM_PORTS x 2 | 0 load, 1 store, 2 exclusive load, 3 exclusive store |
| req_addr_i | input | NUM_PORTS x ADDR_W | Byte address |
| req_size_i | input | NUM_PORTS x 2 | Size code: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes, 3 is 8 bytes |
| req_wdata_i | input | NUM_PORTS x 64 | Write data in byte lanes |
| snoop_valid_i | input | 1 | An outside agent wrote a block |
| snoop_blk_i | input | ADDR_W-3 | Block address of that outside write |
| rvalid_o | output | NUM_PORTS | Read data valid |
| rdata_o | output | NUM_PORTS x 64 | Aligned word returned for a load |
| xs_valid_o | output | NUM_PORTS | Exclusive-store status valid |
| xs_fail_o | output | NUM_PORTS | Status: 0 passed, 1 failed |

## Verification
The directed cases target the failure modes a value-based or loosely tracked monitor would show:

- An intruding store that writes back the value already present. A monitor that compares data would wrongly let the exclusive store pass.
- A second exclusive store with no new exclusive load in between. A reservation that is not cleared would let this store pass twice.
- A replaced reservation. A monitor holding more than one reservation per port would accept a store to the abandoned block.
- The port's own normal store inside its reservation, and a snoop hit. Treating all writes alike, or ignoring the snoop input, gets one of these wrong.

Same-cycle contests are driven on purpose:

- Two exclusive stores to one block in the same cycle. A careless priority scheme lets both of them pass.
- An exclusive load that coincides with another port's store. A careless scheme arms a reservation that is already stale.

Random traffic over a few shared blocks is compared each cycle against a reference model built from the requirements.

// File: rtl/xmon_pkg.sv
package xmon_pkg;
  localparam int unsigned LANES  = 8;
  localparam int unsigned LANE_W = 3;
  localparam int unsigned DATA_W = 64;

  typedef enum logic [1:0] {
    OP_LOAD   = 2'd0,
    OP_STORE  = 2'd1,
    OP_XLOAD  = 2'd2,
    OP_XSTORE = 2'd3
  } op_e;

  // byte enables for a naturally aligned access of 2**size bytes
  function automatic logic [LANES-1:0] lane_mask(logic [1:0] size, logic [LANE_W-1:0] lo);
    logic [LANES-1:0]  base;
    logic [LANE_W-1:0] off;
    case (size)
      2'd0:    base = 8'h01;
      2'd1:    base = 8'h03;
      2'd2:    base = 8'h0f;
      default: base = 8'hff;
    endcase
    off = lo & ~((LANE_W'(1) << size) - LANE_W'(1));
    return base << off;
  endfunction
endpackage

// File: rtl/xmon_mem.sv
module xmon_mem import xmon_pkg::*; #(
  parameter int unsigned NUM_PORTS = 3,
  parameter int unsigned DEPTH     = 16,
  localparam int unsigned IDX_W    = $clog2(DEPTH)
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic [NUM_PORTS-1:0]               rd_en_i,
  input  logic [NUM_PORTS-1:0][IDX_W-1:0]    idx_i,
  input  logic [NUM_PORTS-1:0]               we_i,
  input  logic [NUM_PORTS-1:0][LANES-1:0]    be_i,
  input  logic [NUM_PORTS-1:0][DATA_W-1:0]   wdata_i,
  output logic [NUM_PORTS-1:0][DATA_W-1:0]   rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  // reads see the array before this cycle's writes; later ports override earlier ones
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < int'(DEPTH); w++) mem_q[w] <= '0;
      rdata_o <= '0;
    end else begin
      for (int p = 0; p < int'(NUM_PORTS); p++) begin
        if (rd_en_i[p]) rdata_o[p] <= mem_q[idx_i[p]];
      end
      for (int p = 0; p < int'(NUM_PORTS); p++) begin
        for (int b = 0; b < int'(LANES); b++) begin
          if (we_i[p] && be_i[p][b]) mem_q[idx_i[p]][b*8 +: 8] <= wdata_i[p][b*8 +: 8];
        end
      end
    end
  end
endmodule

// File: rtl/xmon_order.sv
module xmon_order #(
  parameter int unsigned NUM_PORTS = 3,
  parameter int unsigned BLK_W     = 13
) (
  input  logic [NUM_PORTS-1:0]            is_st_i,
  input  logic [NUM_PORTS-1:0]            is_xs_i,
  input  logic [NUM_PORTS-1:0]            res_valid_i,
  input  logic [NUM_PORTS-1:0][BLK_W-1:0] res_blk_i,
  input  logic [NUM_PORTS-1:0][BLK_W-1:0] req_blk_i,
  input  logic                            snp_valid_i,
  input  logic [BLK_W-1:0]                snp_blk_i,
  output logic [NUM_PORTS-1:0]            pass_o,
  output logic [NUM_PORTS-1:0]            wr_eff_o
);
  // snoop first, then ports in ascending index
  always_comb begin
    logic [NUM_PORTS-1:0] wr;
    logic [NUM_PORTS-1:0] ok;
    logic                 blocked;
    wr = '0;
    ok = '0;
    for (int i = 0; i < int'(NUM_PORTS); i++) begin
      blocked = snp_valid_i && (snp_blk_i == req_blk_i[i]);
      for (int j = 0; j < i; j++) begin
        if (wr[j] && (req_blk_i[j] == req_blk_i[i])) blocked = 1'b1;
      end
      ok[i] = is_xs_i[i] && res_valid_i[i] && (res_blk_i[i] == req_blk_i[i]) && !blocked;
      wr[i] = is_st_i[i] || ok[i];
    end
    pass_o   = ok;
    wr_eff_o = wr;
  end
endmodule

// File: rtl/xmon_resv.sv
module xmon_resv #(
  parameter int unsigned NUM_PORTS = 3,
  parameter int unsigned BLK_W     = 13,
  parameter int unsigned PORT_ID   = 0
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            is_xl_i,
  input  logic                            is_xs_i,
  input  logic [BLK_W-1:0]                req_blk_i,
  input  logic [NUM_PORTS-1:0]            wr_eff_i,
  input  logic [NUM_PORTS-1:0][BLK_W-1:0] wr_blk_i,
  input  logic                            snp_valid_i,
  input  logic [BLK_W-1:0]                snp_blk_i,
  output logic                            res_valid_o,
  output logic [BLK_W-1:0]                res_blk_o
);
  logic hit_res, hit_req;

  // writes by anyone but this port
  always_comb begin
    hit_res = snp_valid_i && (snp_blk_i == res_blk_o);
    hit_req = snp_valid_i && (snp_blk_i == req_blk_i);
    for (int j = 0; j < int'(NUM_PORTS); j++) begin
      if (j != int'(PORT_ID) && wr_eff_i[j]) begin
        if (wr_blk_i[j] == res_blk_o) hit_res = 1'b1;
        if (wr_blk_i[j] == req_blk_i) hit_req = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      res_blk_o   <= '0;
    end else if (is_xl_i) begin
      res_valid_o <= !hit_req;
      res_blk_o   <= req_blk_i;
    end else if (is_xs_i || hit_res) begin
      res_valid_o <= 1'b0;
    end
  end

  // R8: exclusive store always consumes the reservation
  p_xs_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_xs_i |=> !res_valid_o);

  // R9: foreign write on the reserved block drops it
  p_foreign_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!is_xl_i && res_valid_o && hit_res) |=> !res_valid_o);

  // R7: a new exclusive load retargets the reservation
  p_rearm_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_xl_i |=> (res_blk_o == $past(req_blk_i)));
endmodule

// File: rtl/excl_monitor.sv
module excl_monitor import xmon_pkg::*; #(
  parameter int unsigned NUM_PORTS = 3,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DEPTH     = 16,
  localparam int unsigned BLK_W    = ADDR_W - LANE_W,
  localparam int unsigned IDX_W    = $clog2(DEPTH)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [NUM_PORTS-1:0]              req_valid_i,
  input  logic [NUM_PORTS-1:0][1:0]         req_type_i,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0]  req_addr_i,
  input  logic [NUM_PORTS-1:0][1:0]         req_size_i,
  input  logic [NUM_PORTS-1:0][DATA_W-1:0]  req_wdata_i,
  input  logic                              snoop_valid_i,
  input  logic [BLK_W-1:0]                  snoop_blk_i,
  output logic [NUM_PORTS-1:0]              rvalid_o,
  output logic [NUM_PORTS-1:0][DATA_W-1:0]  rdata_o,
  output logic [NUM_PORTS-1:0]              xs_valid_o,
  output logic [NUM_PORTS-1:0]              xs_fail_o
);
  logic [NUM_PORTS-1:0]              is_ld, is_st, is_xl, is_xs;
  logic [NUM_PORTS-1:0][BLK_W-1:0]   req_blk, res_blk;
  logic [NUM_PORTS-1:0][IDX_W-1:0]   mem_idx;
  logic [NUM_PORTS-1:0][LANES-1:0]   mem_be;
  logic [NUM_PORTS-1:0]              res_valid, pass, wr_eff;

  always_comb begin
    op_e op;
    for (int i = 0; i < int'(NUM_PORTS); i++) begin
      op         = op_e'(req_type_i[i]);
      is_ld[i]   = req_valid_i[i] && (op == OP_LOAD || op == OP_XLOAD);
      is_st[i]   = req_valid_i[i] && (op == OP_STORE);
      is_xl[i]   = req_valid_i[i] && (op == OP_XLOAD);
      is_xs[i]   = req_valid_i[i] && (op == OP_XSTORE);
      req_blk[i] = req_addr_i[i][ADDR_W-1:LANE_W];
      mem_idx[i] = req_addr_i[i][LANE_W +: IDX_W];
      mem_be[i]  = lane_mask(req_size_i[i], req_addr_i[i][LANE_W-1:0]);
    end
  end

  xmon_order #(.NUM_PORTS(NUM_PORTS), .BLK_W(BLK_W)) u_order (
    .is_st_i     (is_st),
    .is_xs_i     (is_xs),
    .res_valid_i (res_valid),
    .res_blk_i   (res_blk),
    .req_blk_i   (req_blk),
    .snp_valid_i (snoop_valid_i),
    .snp_blk_i   (snoop_blk_i),
    .pass_o      (pass),
    .wr_eff_o    (wr_eff)
  );

  for (genvar g = 0; g < int'(NUM_PORTS); g++) begin : g_resv
    xmon_resv #(.NUM_PORTS(NUM_PORTS), .BLK_W(BLK_W), .PORT_ID(g)) u_resv (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .is_xl_i     (is_xl[g]),
      .is_xs_i     (is_xs[g]),
      .req_blk_i   (req_blk[g]),
      .wr_eff_i    (wr_eff),
      .wr_blk_i    (req_blk),
      .snp_valid_i (snoop_valid_i),
      .snp_blk_i   (snoop_blk_i),
      .res_valid_o (res_valid[g]),
      .res_blk_o   (res_blk[g])
    );
  end

  xmon_mem #(.NUM_PORTS(NUM_PORTS), .DEPTH(DEPTH)) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_en_i (is_ld),
    .idx_i   (mem_idx),
    .we_i    (wr_eff),
    .be_i    (mem_be),
    .wdata_i (req_wdata_i),
    .rdata_o (rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o   <= '0;
      xs_valid_o <= '0;
      xs_fail_o  <= '0;
    end else begin
      rvalid_o   <= is_ld;
      xs_valid_o <= is_xs;
      xs_fail_o  <= is_xs & ~pass;
    end
  end

  for (genvar g = 0; g < int'(NUM_PORTS); g++) begin : g_chk
    // R1 / R11: every load answered next cycle, no stall
    p_load_resp_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      is_ld[g] |=> rvalid_o[g]);
    // R4: status exactly one cycle after an exclusive store
    p_xs_resp_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      is_xs[g] |=> xs_valid_o[g]);
    p_xs_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !is_xs[g] |=> !xs_valid_o[g]);
    // R3: a pass needs a live reservation on the same block
    p_pass_needs_res_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (xs_valid_o[g] && !xs_fail_o[g]) |-> $past(res_valid[g] && res_blk[g] == req_blk[g]));
    for (genvar h = g + 1; h < int'(NUM_PORTS); h++) begin : g_pair
      // R10: at most one exclusive store wins a block per cycle
      p_one_winner_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(pass[g] && pass[h] && req_blk[g] == req_blk[h]));
    end
  end
endmodule

// File: tb/tb_excl_monitor.sv
`timescale 1ns/1ps
module tb_excl_monitor;
  localparam int NP = 3;
  localparam int AW = 16;
  localparam int BW = AW - 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0]         rv;
  logic [NP-1:0][1:0]    rt;
  logic [NP-1:0][AW-1:0] ra;
  logic [NP-1:0][1:0]    rs;
  logic [NP-1:0][63:0]   rw;
  logic                  sv;
  logic [BW-1:0]         sb;
  logic [NP-1:0]         o_rv, o_xv, o_xf;
  logic [NP-1:0][63:0]   o_rd;

  int n_cmp = 0;
  int n_bad = 0;

  logic [63:0] m_mem [16];
  bit          m_rv  [NP];
  logic [BW-1:0] m_rb [NP];

  always #10 clk = ~clk;

  excl_monitor #(.NUM_PORTS(NP), .ADDR_W(AW), .DEPTH(16)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(rv), .req_type_i(rt), .req_addr_i(ra),
    .req_size_i(rs), .req_wdata_i(rw), .snoop_valid_i(sv), .snoop_blk_i(sb),
    .rvalid_o(o_rv), .rdata_o(o_rd), .xs_valid_o(o_xv), .xs_fail_o(o_xf));

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] bmask(logic [1:0] size, logic [2:0] lo);
    int n = 1 << size;
    int off = (int'(lo) / n) * n;
    return 8'(((1 << n) - 1) << off);
  endfunction

  task automatic idle();
    rv = '0; rt = '0; ra = '0; rs = '0; rw = '0; sv = 1'b0; sb = '0;
  endtask

  task automatic put(int p, int t, int addr, int size, logic [63:0] d);
    rv[p] = 1'b1; rt[p] = 2'(t); ra[p] = AW'(addr); rs[p] = 2'(size); rw[p] = d;
  endtask

  // reference model step, then compare outputs one cycle later
  task automatic step(string xtag);
    bit ld[NP], st[NP], xl[NP], xs[NP], wr[NP], ps[NP], hq[NP], hr[NP];
    logic [BW-1:0] bk[NP];
    logic [63:0] erd[NP];
    bit blocked;
    for (int i = 0; i < NP; i++) begin
      ld[i] = rv[i] && (rt[i] == 0 || rt[i] == 2);
      st[i] = rv[i] && rt[i] == 1;
      xl[i] = rv[i] && rt[i] == 2;
      xs[i] = rv[i] && rt[i] == 3;
      bk[i] = ra[i][AW-1:3];
      erd[i] = m_mem[ra[i][6:3]];
    end
    for (int i = 0; i < NP; i++) begin
      blocked = sv && sb == bk[i];
      for (int j = 0; j < i; j++) if (wr[j] && bk[j] == bk[i]) blocked = 1;
      ps[i] = xs[i] && m_rv[i] && m_rb[i] == bk[i] && !blocked;
      wr[i] = st[i] || ps[i];
    end
    for (int i = 0; i < NP; i++) begin
      hq[i] = sv && sb == bk[i];
      hr[i] = sv && sb == m_rb[i];
      for (int j = 0; j < NP; j++) if (j != i && wr[j]) begin
        if (bk[j] == bk[i]) hq[i] = 1;
        if (bk[j] == m_rb[i]) hr[i] = 1;
      end
    end
    for (int i = 0; i < NP; i++) if (wr[i]) begin
      logic [7:0] m = bmask(rs[i], ra[i][2:0]);
      for (int b = 0; b < 8; b++) if (m[b]) m_mem[ra[i][6:3]][b*8 +: 8] = rw[i][b*8 +: 8];
    end
    for (int i = 0; i < NP; i++) begin
      if (xl[i]) begin m_rv[i] = !hq[i]; m_rb[i] = bk[i]; end
      else if (xs[i] || hr[i]) m_rv[i] = 0;
    end
    @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < NP; i++) begin
      chk("R1 rvalid", 64'(o_rv[i]), 64'(ld[i]));
      if (ld[i]) chk("R1 rdata", o_rd[i], erd[i]);
      chk("R4 xs_valid", 64'(o_xv[i]), 64'(xs[i]));
      if (xs[i]) chk(xtag, 64'(o_xf[i]), 64'(!ps[i]));
    end
    idle();
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    idle();
    for (int w = 0; w < 16; w++) m_mem[w] = '0;
    for (int i = 0; i < NP; i++) begin m_rv[i] = 0; m_rb[i] = '0; end
    repeat (3) @(negedge clk);
    chk("R12 rvalid", 64'(o_rv), 64'd0);
    chk("R12 xs_valid", 64'(o_xv), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R12: no reservation after reset; R5: nothing written
    put(0, 3, 'h40, 3, 64'hdead_beef_0000_1111); step("R12 xs_fail");
    put(0, 0, 'h40, 3, 0); step("R1");
    chk("R5 rdata", o_rd[0], 64'd0);

    // R2 byte lanes and size alignment
    put(0, 1, 'h11, 0, 64'h5555_5555_5555_aa55); step("R2");
    put(1, 1, 'h16, 1, 64'hbbcc_7777_7777_7777); step("R2");
    put(2, 1, 'h13, 2, 64'hffff_ffff_1122_3344); step("R2");
    put(1, 0, 'h10, 0, 0); step("R2");
    chk("R2 rdata", o_rd[1], 64'hbbcc_0000_1122_3344);

    // R3 pass, then R8 second store fails
    put(0, 2, 'h20, 3, 0); step("R3");
    put(0, 3, 'h24, 2, 64'h0000_0000_cafe_f00d); step("R3 xs_fail");
    chk("R3 status", 64'(o_xf[0]), 64'd0);
    put(0, 3, 'h20, 3, 64'h1); step("R8 xs_fail");
    chk("R8 status", 64'(o_xf[0]), 64'd1);

    // R6 same value rewritten still breaks the reservation
    put(0, 2, 'h28, 3, 0); step("R6");
    put(1, 1, 'h28, 3, o_rd[0]); step("R6");
    put(0, 3, 'h28, 3, 64'h77); step("R6 xs_fail");
    chk("R6 status", 64'(o_xf[0]), 64'd1);

    // R9 foreign store, own store, snoop
    put(0, 2, 'h30, 3, 0); step("R9");
    put(2, 1, 'h37, 0, 64'h0100_0000_0000_0000); step("R9");
    put(0, 3, 'h30, 3, 64'h9); step("R9 xs_fail");
    chk("R9 foreign", 64'(o_xf[0]), 64'd1);
    put(0, 2, 'h30, 3, 0); step("R9");
    put(0, 1, 'h31, 0, 64'h0000_0000_0000_4200); step("R9");
    put(0, 3, 'h30, 3, 64'h9); step("R9 xs_fail");
    chk("R9 own", 64'(o_xf[0]), 64'd0);
    put(1, 2, 'h38, 3, 0); step("R9");
    sv = 1'b1; sb = BW'('h38 >> 3); step("R9");
    put(1, 3, 'h3c, 2, 64'h5); step("R9 xs_fail");
    chk("R9 snoop", 64'(o_xf[1]), 64'd1);

    // R7 replacement
    put(0, 2, 'h40, 3, 0); step("R7");
    put(0, 2, 'h48, 3, 0); step("R7");
    put(0, 3, 'h40, 3, 64'h3); step("R7 xs_fail");
    chk("R7 old", 64'(o_xf[0]), 64'd1);
    put(0, 2, 'h40, 3, 0); step("R7");
    put(0, 2, 'h48, 3, 0); step("R7");
    put(0, 3, 'h48, 3, 64'h3); step("R7 xs_fail");
    chk("R7 new", 64'(o_xf[0]), 64'd0);

    // R10 same-cycle ordering
    put(0, 2, 'h50, 3, 0); put(1, 2, 'h50, 3, 0); step("R10");
    put(0, 3, 'h50, 3, 64'ha); put(1, 3, 'h54, 2, 64'hb); step("R10 xs_fail");
    chk("R10 low wins", 64'(o_xf[0]), 64'd0);
    chk("R10 high loses", 64'(o_xf[1]), 64'd1);
    put(2, 1, 'h58, 3, 64'h12); put(1, 2, 'h58, 3, 0); step("R10");
    put(1, 3, 'h58, 3, 64'h34); step("R10 xs_fail");
    chk("R10 no arm", 64'(o_xf[1]), 64'd1);

    // R11 all ports in parallel
    put(0, 0, 'h10, 3, 0); put(1, 2, 'h28, 3, 0); put(2, 0, 'h58, 3, 0); step("R11");
    chk("R11 all served", 64'(o_rv), 64'h7);

    // random traffic on a few shared blocks
    for (int k = 0; k < 4000; k++) begin
      for (int p = 0; p < NP; p++) begin
        if ($urandom % 4 != 0)
          put(p, int'($urandom % 4), int'(('h40 + ($urandom % 4) * 8) + ($urandom % 8)),
              int'($urandom % 4), {$urandom, $urandom});
      end
      if ($urandom % 10 == 0) begin sv = 1'b1; sb = BW'(8 + $urandom % 4); end
      step("R3 random xs_fail");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule